// File: doc/BRIEF.md
# Parallel FFT guard with parity transform and energy checks

The block computes four independent 4-point complex transforms in parallel and protects them against a single soft error with a fifth, redundant transform. The redundant transform runs on the bin-wise sum of the four input frames. Every one of the five transforms has its own energy check. The energy check compares the summed squared magnitudes of the output bins with four times the summed squared magnitudes of the input samples. When the two energies differ by more than a programmable tolerance, that unit is marked faulty.

A lone faulty engine is repaired bin by bin. Its output is rebuilt as the redundant transform output minus the outputs of the three healthy engines, saturated to the output width. A fault seen only in the redundant transform is reported, and the four engine outputs are delivered as they are. If two or more checks fail in one frame, the frame is marked uncorrectable and passed through unchanged. The checks and the repair add a fixed pipeline delay. The output valid strobe follows the input strobe by exactly three cycles, so one frame can be accepted every cycle.

The block has a soft-error emulation input. It flips chosen bits in the real part of one bin of any chosen units for the frame being captured. This is the only way the protection path can be exercised from the pins.

Top module: `par_fft_guard`

## Requirements
- R1: With no emulated fault, output bin k of engine e (field index e*4+k of y_re/y_im, each OW = W+2 bits, two's complement) equals the exact unscaled 4-point DFT X[k] = sum over n of x[n]·e^(−j2πkn/4) of that engine's input samples (field index e*4+n of x_re/x_im, W bits each).
- R2: Bit e of err_eng (e = 0..3) is set for a frame when |sum_k |X[k]|² − 4·sum_n |x[n]|²| of engine e exceeds thr. err_par applies the same test to the redundant transform, whose input sample n is the sum of sample n of the four engines.
- R3: An energy difference equal to thr does not mark the unit; thr one below that difference does mark it. An unmarked unit's output is delivered unmodified.
- R4: When exactly one engine is marked and the redundant transform is not, fixed is set. That engine's bins are replaced by redundant output minus the other three engine outputs, saturated to OW bits.
- R5: When only the redundant transform is marked, err_par is set, fixed and uncorr stay low, and the engine outputs are delivered unmodified.
- R6: When two or more of the five checks fail in one frame, uncorr is set, fixed stays low, and all engine outputs are delivered unmodified.
- R7: out_valid is high exactly three cycles after each cycle in which in_valid is high, including for frames on consecutive cycles.
- R8: After reset, and in every cycle without out_valid, out_valid, err_eng, err_par, uncorr and fixed are all low.
- R9: For a captured frame, setting bit u of inj_units (bits 0..3 are the engines, bit 4 is the redundant transform) XORs inj_mask into the low OW bits of the real part of bin inj_bin of that unit's result, before its energy check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frames valid this cycle |
| x_re | input | 16*W | Real parts of input samples, field e*4+n |
| x_im | input | 16*W | Imaginary parts of input samples, field e*4+n |
| thr | input | 2*W+10 | Energy mismatch tolerance |
| inj_units | input | 5 | Units receiving an emulated fault |
| inj_bin | input | 2 | Bin receiving the emulated fault |
| inj_mask | input | W+2 | Bit pattern XORed into the faulted bin's real part |
| out_valid | output | 1 | Output frames valid |
| y_re | output | 16*(W+2) | Real parts of output bins, field e*4+k |
| y_im | output | 16*(W+2) | Imaginary parts of output bins, field e*4+k |
| err_eng | output | 4 | Per-engine energy check failures |
| err_par | output | 1 | Redundant transform energy check failure |
| uncorr | output | 1 | Two or more checks failed; outputs not repaired |
| fixed | output | 1 | One engine output was rebuilt |

## Verification
The hardest state to reach is the tolerance boundary, where an engine's energy mismatch lands exactly on thr. The bench's own model computes the mismatch that a small emulated fault produces on a chosen frame. It then sends that frame twice, once with thr equal to the mismatch and once with thr one below it, and expects pass-through in the first case and repair in the second. Multi-fault frames are reached by setting several inj_units bits at once. Repair during back-to-back traffic is covered by streaming faulted frames on consecutive cycles.

// File: rtl/par_fft_guard.sv
module par_fft_guard #(
  parameter int W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [16*W-1:0]       x_re,
  input  logic [16*W-1:0]       x_im,
  input  logic [2*W+9:0]        thr,
  input  logic [4:0]            inj_units,
  input  logic [1:0]            inj_bin,
  input  logic [W+1:0]          inj_mask,
  output logic                  out_valid,
  output logic [16*(W+2)-1:0]   y_re,
  output logic [16*(W+2)-1:0]   y_im,
  output logic [3:0]            err_eng,
  output logic                  err_par,
  output logic                  uncorr,
  output logic                  fixed
);
  localparam int OW = W + 2;
  localparam int PW = W + 4;
  localparam int RW = PW + 1;
  localparam int EW = 2 * PW + 2;
  localparam int NU = 5;
  localparam logic signed [RW-1:0] SMAX = RW'((1 << (OW - 1)) - 1);
  localparam logic signed [RW-1:0] SMIN = -SMAX - RW'(1);

  function automatic logic [EW-1:0] mag2(input logic signed [PW-1:0] a, input logic signed [PW-1:0] b);
    logic signed [EW-1:0] s;
    s = EW'(a) * EW'(a) + EW'(b) * EW'(b);
    return s;
  endfunction

  function automatic logic [OW-1:0] sat(input logic signed [RW-1:0] v);
    if (v > SMAX) return {1'b0, {(OW-1){1'b1}}};
    else if (v < SMIN) return {1'b1, {(OW-1){1'b0}}};
    else return v[OW-1:0];
  endfunction

  logic signed [PW-1:0] ur [NU][4];
  logic signed [PW-1:0] ui [NU][4];
  logic signed [PW-1:0] fr [NU][4];
  logic signed [PW-1:0] fi [NU][4];
  logic signed [PW-1:0] fq [NU][4];
  logic [EW-1:0] ein [NU];

  genvar u, n;
  generate
    for (u = 0; u < 4; u++) begin : g_in
      for (n = 0; n < 4; n++) begin : g_smp
        assign ur[u][n] = PW'($signed(x_re[(u*4+n)*W +: W]));
        assign ui[u][n] = PW'($signed(x_im[(u*4+n)*W +: W]));
      end
    end
    for (n = 0; n < 4; n++) begin : g_sum
      assign ur[4][n] = ur[0][n] + ur[1][n] + ur[2][n] + ur[3][n];
      assign ui[4][n] = ui[0][n] + ui[1][n] + ui[2][n] + ui[3][n];
    end

    for (u = 0; u < NU; u++) begin : g_fft
      logic signed [PW-1:0] a0r, a0i, a1r, a1i, b0r, b0i, b1r, b1i;
      assign a0r = ur[u][0] + ur[u][2];
      assign a0i = ui[u][0] + ui[u][2];
      assign a1r = ur[u][0] - ur[u][2];
      assign a1i = ui[u][0] - ui[u][2];
      assign b0r = ur[u][1] + ur[u][3];
      assign b0i = ui[u][1] + ui[u][3];
      assign b1r = ur[u][1] - ur[u][3];
      assign b1i = ui[u][1] - ui[u][3];
      assign fr[u][0] = a0r + b0r;
      assign fi[u][0] = a0i + b0i;
      assign fr[u][1] = a1r + b1i;
      assign fi[u][1] = a1i - b1r;
      assign fr[u][2] = a0r - b0r;
      assign fi[u][2] = a0i - b0i;
      assign fr[u][3] = a1r - b1i;
      assign fi[u][3] = a1i + b1r;
      assign ein[u] = (mag2(ur[u][0], ui[u][0]) + mag2(ur[u][1], ui[u][1]) +
                       mag2(ur[u][2], ui[u][2]) + mag2(ur[u][3], ui[u][3])) << 2;
      for (n = 0; n < 4; n++) begin : g_inj
        logic hit;
        assign hit = inj_units[u] && (inj_bin == 2'(n));
        if (u < 4) begin : g_eng
          assign fq[u][n] = hit ? PW'($signed(fr[u][n][OW-1:0] ^ inj_mask)) : fr[u][n];
        end else begin : g_par
          assign fq[u][n] = hit ? (fr[u][n] ^ PW'(inj_mask)) : fr[u][n];
        end
      end
    end
  endgenerate

  logic signed [PW-1:0] xr1 [NU][4];
  logic signed [PW-1:0] xi1 [NU][4];
  logic [EW-1:0] ein1 [NU];
  logic v1;

  always_ff @(posedge clk) begin
    xr1  <= fq;
    xi1  <= fi;
    ein1 <= ein;
  end

  logic [EW-1:0] eout [NU];
  logic [NU-1:0] flg;

  generate
    for (u = 0; u < NU; u++) begin : g_chk
      assign eout[u] = mag2(xr1[u][0], xi1[u][0]) + mag2(xr1[u][1], xi1[u][1]) +
                       mag2(xr1[u][2], xi1[u][2]) + mag2(xr1[u][3], xi1[u][3]);
      assign flg[u] = ((eout[u] > ein1[u]) ? (eout[u] - ein1[u]) : (ein1[u] - eout[u])) > thr;
    end
  endgenerate

  logic signed [PW-1:0] xr2 [NU][4];
  logic signed [PW-1:0] xi2 [NU][4];
  logic [NU-1:0] flg2;
  logic v2;

  always_ff @(posedge clk) begin
    xr2  <= xr1;
    xi2  <= xi1;
    flg2 <= flg;
  end

  logic [2:0] nfl;
  logic sole;
  logic [16*OW-1:0] yr_n, yi_n;

  assign nfl  = 3'($countones(flg2));
  assign sole = (nfl == 3'd1) && !flg2[4];

  genvar e, k;
  generate
    for (e = 0; e < 4; e++) begin : g_fix
      for (k = 0; k < 4; k++) begin : g_bin
        logic signed [RW-1:0] rr, ri;
        assign rr = RW'(xr2[4][k]) - RW'(xr2[(e+1)%4][k]) - RW'(xr2[(e+2)%4][k]) - RW'(xr2[(e+3)%4][k]);
        assign ri = RW'(xi2[4][k]) - RW'(xi2[(e+1)%4][k]) - RW'(xi2[(e+2)%4][k]) - RW'(xi2[(e+3)%4][k]);
        assign yr_n[(e*4+k)*OW +: OW] = (sole && flg2[e]) ? sat(rr) : xr2[e][k][OW-1:0];
        assign yi_n[(e*4+k)*OW +: OW] = (sole && flg2[e]) ? sat(ri) : xi2[e][k][OW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    y_re <= yr_n;
    y_im <= yi_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      err_eng   <= '0;
      err_par   <= 1'b0;
      uncorr    <= 1'b0;
      fixed     <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      err_eng   <= v2 ? flg2[3:0] : 4'b0;
      err_par   <= v2 && flg2[4];
      uncorr    <= v2 && (nfl >= 3'd2);
      fixed     <= v2 && sole;
    end
  end
endmodule

module par_fft_guard_chk #(
  parameter int W = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [3:0] err_eng,
  input logic       err_par,
  input logic       uncorr,
  input logic       fixed
);
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  p_single_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $countones(err_eng) == 1 && !err_par) |-> fixed);

  p_fix_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fixed |-> ($countones(err_eng) == 1 && !err_par && !uncorr));

  p_par_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && $countones(err_eng) == 0) |-> (!fixed && !uncorr));

  p_multi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({err_eng, err_par}) >= 2) |-> (uncorr && !fixed));

  p_uncorr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> ($countones({err_eng, err_par}) >= 2));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (err_eng == 4'b0 && !err_par && !uncorr && !fixed));
endmodule

bind par_fft_guard par_fft_guard_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .err_eng(err_eng), .err_par(err_par), .uncorr(uncorr), .fixed(fixed)
);

// File: tb/par_fft_guard_bench.sv
module par_fft_guard_bench;
  localparam int W  = 12;
  localparam int OW = W + 2;
  localparam int EW = 2 * W + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [16*W-1:0] x_re = '0;
  logic [16*W-1:0] x_im = '0;
  logic [EW-1:0] thr = '0;
  logic [4:0] inj_units = '0;
  logic [1:0] inj_bin = '0;
  logic [OW-1:0] inj_mask = '0;
  logic out_valid;
  logic [16*OW-1:0] y_re, y_im;
  logic [3:0] err_eng;
  logic err_par, uncorr, fixed;

  par_fft_guard #(.W(W)) u_par_fft_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_re(x_re), .x_im(x_im),
    .thr(thr), .inj_units(inj_units), .inj_bin(inj_bin), .inj_mask(inj_mask),
    .out_valid(out_valid), .y_re(y_re), .y_im(y_im), .err_eng(err_eng),
    .err_par(err_par), .uncorr(uncorr), .fixed(fixed)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [16*OW-1:0] yr;
    logic [16*OW-1:0] yi;
    logic [3:0] ee;
    logic ep;
    logic uc;
    logic fx;
  } exp_t;

  exp_t   q_exp[$];
  longint q_t[$];
  string  q_tag[$];
  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  function automatic longint sx(input longint v, input int b);
    longint m;
    m = v & ((longint'(1) << b) - 1);
    if (m >= (longint'(1) << (b - 1))) m = m - (longint'(1) << b);
    return m;
  endfunction

  task automatic model(input longint xr[16], input longint xi[16], input logic [4:0] units,
                       input logic [1:0] bin, input logic [OW-1:0] mask,
                       output exp_t ex, output longint dif[5]);
    longint ur[5][4], ui[5][4], R[5][4], I[5][4];
    longint a0r, a0i, a1r, a1i, b0r, b0i, b1r, b1i, ein, eout, v, vi;
    longint lo, hi;
    logic [4:0] fl;
    int nf;
    bit sole;
    lo = -(longint'(1) << (OW - 1));
    hi = (longint'(1) << (OW - 1)) - 1;
    for (int n = 0; n < 4; n++) begin
      ur[4][n] = 0; ui[4][n] = 0;
      for (int u = 0; u < 4; u++) begin
        ur[u][n] = xr[u*4+n]; ui[u][n] = xi[u*4+n];
        ur[4][n] += xr[u*4+n]; ui[4][n] += xi[u*4+n];
      end
    end
    for (int u = 0; u < 5; u++) begin
      a0r = ur[u][0] + ur[u][2]; a0i = ui[u][0] + ui[u][2];
      a1r = ur[u][0] - ur[u][2]; a1i = ui[u][0] - ui[u][2];
      b0r = ur[u][1] + ur[u][3]; b0i = ui[u][1] + ui[u][3];
      b1r = ur[u][1] - ur[u][3]; b1i = ui[u][1] - ui[u][3];
      R[u][0] = a0r + b0r; I[u][0] = a0i + b0i;
      R[u][1] = a1r + b1i; I[u][1] = a1i - b1r;
      R[u][2] = a0r - b0r; I[u][2] = a0i - b0i;
      R[u][3] = a1r - b1i; I[u][3] = a1i + b1r;
      if (units[u]) begin
        if (u < 4) R[u][bin] = sx(R[u][bin] ^ longint'(mask), OW);
        else       R[u][bin] = R[u][bin] ^ longint'(mask);
      end
      ein = 0; eout = 0;
      for (int n = 0; n < 4; n++) begin
        ein  += ur[u][n] * ur[u][n] + ui[u][n] * ui[u][n];
        eout += R[u][n] * R[u][n] + I[u][n] * I[u][n];
      end
      ein = 4 * ein;
      dif[u] = (eout > ein) ? eout - ein : ein - eout;
      fl[u] = dif[u] > longint'(thr);
    end
    nf = $countones(fl);
    sole = (nf == 1) && !fl[4];
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < 4; k++) begin
        v = R[e][k]; vi = I[e][k];
        if (sole && fl[e]) begin
          v = R[4][k]; vi = I[4][k];
          for (int j = 0; j < 4; j++) if (j != e) begin v -= R[j][k]; vi -= I[j][k]; end
          if (v > hi) v = hi; if (v < lo) v = lo;
          if (vi > hi) vi = hi; if (vi < lo) vi = lo;
        end
        ex.yr[(e*4+k)*OW +: OW] = v[OW-1:0];
        ex.yi[(e*4+k)*OW +: OW] = vi[OW-1:0];
      end
    end
    ex.ee = fl[3:0];
    ex.ep = fl[4];
    ex.uc = (nf >= 2);
    ex.fx = sole;
  endtask

  task automatic send(input longint xr[16], input longint xi[16], input string tag,
                      input logic [4:0] units, input logic [1:0] bin, input logic [OW-1:0] mask);
    exp_t ex;
    longint dif[5];
    model(xr, xi, units, bin, mask, ex, dif);
    @(negedge clk);
    for (int j = 0; j < 16; j++) begin
      x_re[j*W +: W] = xr[j][W-1:0];
      x_im[j*W +: W] = xi[j][W-1:0];
    end
    inj_units = units; inj_bin = bin; inj_mask = mask;
    in_valid = 1'b1;
    q_exp.push_back(ex);
    q_t.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    inj_units = '0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) begin
        chk(0, "R7", "out_valid with no frame pending: actual 1 expected 0");
      end else begin
        exp_t ex;
        longint t;
        string tg;
        ex = q_exp.pop_front(); t = q_t.pop_front(); tg = q_tag.pop_front();
        chk(y_re == ex.yr && y_im == ex.yi, tg,
            $sformatf("bins actual re=%h im=%h expected re=%h im=%h", y_re, y_im, ex.yr, ex.yi));
        chk({err_eng, err_par, uncorr, fixed} == {ex.ee, ex.ep, ex.uc, ex.fx}, tg,
            $sformatf("flags eng/par/unc/fix actual %b expected %b",
                      {err_eng, err_par, uncorr, fixed}, {ex.ee, ex.ep, ex.uc, ex.fx}));
        chk(cyc - t == 3, "R7", $sformatf("latency actual %0d expected 3", cyc - t));
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R7", "watchdog expired: actual hung expected done");
    report();
  end

  function automatic longint rnd();
    return longint'($urandom_range(4095)) - 2048;
  endfunction

  initial begin
    longint xr[16], xi[16], dif[5];
    exp_t ex;
    int s;
    s = $urandom(32'd11);
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && err_eng == 0 && !err_par && !uncorr && !fixed, "R8",
        $sformatf("in reset actual %b expected 0", {out_valid, err_eng, err_par, uncorr, fixed}));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && err_eng == 0 && !err_par && !uncorr && !fixed, "R8",
        $sformatf("after reset actual %b expected 0", {out_valid, err_eng, err_par, uncorr, fixed}));

    for (int j = 0; j < 16; j++) begin xr[j] = 0; xi[j] = 0; end
    send(xr, xi, "R1 zeros", 5'b0, 2'd0, '0);
    for (int j = 0; j < 16; j++) begin xr[j] = j * 100 - 800; xi[j] = 700 - j * 90; end
    send(xr, xi, "R1 ramp", 5'b0, 2'd0, '0);
    for (int j = 0; j < 16; j++) begin xr[j] = -2048; xi[j] = -2048; end
    send(xr, xi, "R1 extreme", 5'b0, 2'd0, '0);
    for (int j = 0; j < 16; j++) begin xr[j] = (j % 2) ? 2047 : -2048; xi[j] = (j % 3) ? -2048 : 2047; end
    send(xr, xi, "R1 alternating", 5'b0, 2'd0, '0);
    for (int r = 0; r < 3; r++) begin
      for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
      send(xr, xi, "R2 clean random", 5'b0, 2'd0, '0);
    end
    idle(4);

    for (int e = 0; e < 4; e++) begin
      for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
      send(xr, xi, "R4 R9 single engine fault", 5'(1 << e), 2'(e), 14'h0155);
    end
    for (int j = 0; j < 16; j++) begin xr[j] = -2048; xi[j] = 2047; end
    send(xr, xi, "R4 extreme repair", 5'b00010, 2'd0, 14'h2000);
    idle(3);

    for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
    send(xr, xi, "R5 R9 parity fault", 5'b10000, 2'd1, 14'h0aa0);
    for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
    send(xr, xi, "R6 two engines", 5'b00011, 2'd2, 14'h0300);
    for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
    send(xr, xi, "R6 engine plus parity", 5'b10100, 2'd3, 14'h1111);
    idle(5);

    dif[2] = 0;
    for (int tries = 0; tries < 20 && dif[2] == 0; tries++) begin
      for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
      model(xr, xi, 5'b00100, 2'd1, 14'h0003, ex, dif);
    end
    thr = EW'(dif[2]);
    send(xr, xi, "R3 mismatch equals tolerance", 5'b00100, 2'd1, 14'h0003);
    idle(5);
    thr = EW'(dif[2] - 1);
    send(xr, xi, "R3 mismatch above tolerance", 5'b00100, 2'd1, 14'h0003);
    idle(5);
    thr = '0;
    idle(2);

    for (int r = 0; r < 8; r++) begin
      for (int j = 0; j < 16; j++) begin xr[j] = rnd(); xi[j] = rnd(); end
      send(xr, xi, "R7 R4 back-to-back", 5'(1 << (r % 5)), 2'(r), 14'(16'h0421 << (r % 3)));
    end
    idle(8);
    chk(q_exp.size() == 0, "R7", $sformatf("pending frames actual %0d expected 0", q_exp.size()));
    report();
  end
endmodule